// File: doc/BRIEF.md
# Shared-Slot Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It has sixteen maskable vector slots. The first eight slots are each fed by one of two candidate sources, chosen by a source-select register. The other eight have a single source. Each slot holds a request latch, which is set by a rising edge on the selected source level, and an enable bit. A global mask flag blocks every maskable slot. Two events are always let through: the reset condition and a software break trap.

External pins pass through a two-flop synchronizer and a programmable polarity stage before they reach their slots. A pin-swap bit moves external inputs 0 and 4 over to a pair of alternate pins. The edge detector compares each slot's final selected level with its value one cycle earlier. Because of this, a change to a selection or polarity register that raises the level sets the request exactly as a real edge would. Software must clear that request before it trusts the slot.

The core sees a pending output and a vector index. It answers with a one-cycle acknowledge. The acknowledge sets the mask flag and retires the winning source. The mask flag is cleared only through a dedicated clear input, which stands for the status restore at return from interrupt.

Top module: `intc_shared_top`

## Requirements
- R1: A maskable slot s can win only when its request bit is 1, its enable bit is 1 and the mask flag `iflag` is 0. A winning slot s is presented as vector index s+1.
- R2: A register write to a request byte clears each request bit whose data bit is 0. A data bit of 1 leaves that request bit unchanged, so software can never set a request.
- R3: The reset condition (index 0) and the break trap (index 17) are pending regardless of `iflag` and the enable bits. The reset condition is pending from reset until it is acknowledged. A `brk_req` pulse latches the break trap until it is acknowledged.
- R4: Priority is fixed: reset first, then slots from the lowest slot number upward, then the break trap last. `irq_vec` shows the winner's index.
- R5: On a cycle with `irq_ack`=1 and `irq_pend`=1, the controller sets `iflag` and retires the winner: it clears the slot's request bit, or clears the reset or break condition. `irq_pend` deasserts on the next cycle unless another source qualifies.
- R6: Source-select register (address 0x39), bit n for n<8: a value of 0 feeds slot n from its primary source and a value of 1 feeds it from its alternate source `alt_src[n]`.
- R7: Edge register (address 0x3A), bit 6: a value of 1 feeds external inputs 0 and 4 from `ext_alt[0]` and `ext_alt[1]` in place of `ext_pin[0]` and `ext_pin[4]`.
- R8: Edge register bit e, for e<5, sets the polarity of external input e: 0 detects a rising edge and 1 detects a falling edge.
- R9: A source-select or edge-register write that makes a slot's selected level go from 0 to 1 sets that slot's request bit, one cycle after the write.
- R10: When a hardware edge arrives in the same cycle as a software clear or an acknowledge clear of the same slot, the request bit ends at 1.
- R11: `iflag` resets to 1 and is cleared by `iflag_clr`. An acknowledge in the same cycle keeps it at 1.
- R12: An external pin edge sets its request bit on the third rising clock edge after the pin changes. An internal source `int_src[i]` drives slot i+5, and its rising edge sets the request on the first clock edge.
- R13: Register map: 0x39 is the source select and 0x3A is the edge register. Request bytes are at 0x3C (slots 0-7) and 0x3D (slots 8-15). Enable bytes are at 0x3E and 0x3F. Every other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 5 | Asynchronous external interrupt pins, primary sources of slots 0-4 |
| ext_alt | input | 2 | Alternate pins for external inputs 0 and 4 |
| int_src | input | 11 | Synchronous internal source levels for slots 5-15 |
| alt_src | input | 8 | Alternate source levels for shared slots 0-7 |
| brk_req | input | 1 | Software break trap request pulse |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| iflag_clr | input | 1 | Clears the mask flag (status restore) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on address |
| irq_pend | output | 1 | A qualified source is pending |
| irq_vec | output | 5 | Vector index of the winner |
| iflag | output | 1 | Global mask flag |

## Verification
The bench builds the block with its defaults: sixteen slots, eight shared pairs and five external inputs. With these values both swappable external inputs exist, and there are shared slots that are also external inputs, shared slots fed by internal sources, and unshared slots. Both request and enable bytes can be reached, and the break index 17 sits above every slot index. Directed sequences cover spurious sets from selection and polarity writes and the three-cycle pin latency. A long random run, checked each cycle against a behavioural model, reaches the same-cycle races between acknowledge, software clear and new edges.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam logic [7:0] ADDR_SRCSEL   = 8'h39;
  localparam logic [7:0] ADDR_EDGESEL  = 8'h3A;
  localparam logic [7:0] ADDR_REQ_BASE = 8'h3C;
  localparam int unsigned PINSEL_BIT   = 6;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_RESET = 2'd1,
    WIN_SLOT  = 2'd2,
    WIN_BRK   = 2'd3
  } win_kind_e;
endpackage

// File: rtl/intc_edge_front.sv
`timescale 1ns/1ps
module intc_edge_front #(
  parameter int unsigned NUM_EXT    = 5,
  parameter int unsigned ALT_LO_IDX = 0,
  parameter int unsigned ALT_HI_IDX = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] pin_main,
  input  logic [1:0]         pin_alt,
  input  logic [NUM_EXT-1:0] fall_sel,
  input  logic               pin_swap,
  output logic [NUM_EXT-1:0] ext_lvl
);
  localparam int unsigned SYNC_W = NUM_EXT + 2;

  logic [SYNC_W-1:0] meta_q, sync_q;
  logic [SYNC_W-1:0] meta_d, sync_d;

  always_comb begin
    meta_d = {pin_alt, pin_main};
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      logic picked;
      if (e == ALT_LO_IDX) begin : g_swap_lo
        assign picked = pin_swap ? sync_q[NUM_EXT] : sync_q[e];
      end else if (e == ALT_HI_IDX) begin : g_swap_hi
        assign picked = pin_swap ? sync_q[NUM_EXT+1] : sync_q[e];
      end else begin : g_fixed
        assign picked = sync_q[e];
      end
      assign ext_lvl[e] = picked ^ fall_sel[e];
    end
  endgenerate
endmodule

// File: rtl/intc_slot_bank.sv
`timescale 1ns/1ps
module intc_slot_bank #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_PAIRS = 8
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] lvl_a,
  input  logic [NUM_PAIRS-1:0] lvl_b,
  input  logic [NUM_PAIRS-1:0] src_sel,
  input  logic [NUM_SLOTS-1:0] sw_clr,
  input  logic [NUM_SLOTS-1:0] ack_clr,
  output logic [NUM_SLOTS-1:0] req,
  output logic [NUM_SLOTS-1:0] rise
);
  logic [NUM_SLOTS-1:0] lvl;
  logic [NUM_SLOTS-1:0] prev_q, req_q, req_d;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s < NUM_PAIRS) begin : g_shared
        assign lvl[s] = src_sel[s] ? lvl_b[s] : lvl_a[s];
      end else begin : g_single
        assign lvl[s] = lvl_a[s];
      end
    end
  endgenerate

  assign rise = lvl & ~prev_q;

  // A new edge always wins over any clear in the same cycle.
  always_comb begin
    req_d = (req_q & ~sw_clr & ~ack_clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= lvl;
      req_q  <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
module intc_prio
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [NUM_SLOTS-1:0] req,
  input  logic [NUM_SLOTS-1:0] en,
  input  logic                 mask,
  input  logic                 reset_pend,
  input  logic                 brk_pend,
  output logic                 pend,
  output logic [IDX_W-1:0]     idx,
  output win_kind_e            kind,
  output logic [NUM_SLOTS-1:0] win_slot
);
  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(NUM_SLOTS + 1);

  logic [NUM_SLOTS-1:0] qual;
  logic [IDX_W-1:0]     slot_idx;

  always_comb begin
    qual     = mask ? '0 : (req & en);
    win_slot = qual & (~qual + NUM_SLOTS'(1));
    slot_idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (win_slot[s]) slot_idx = IDX_W'(s + 1);
    end
  end

  always_comb begin
    if (reset_pend) begin
      kind = WIN_RESET;
      idx  = '0;
    end else if (|qual) begin
      kind = WIN_SLOT;
      idx  = slot_idx;
    end else if (brk_pend) begin
      kind = WIN_BRK;
      idx  = BRK_IDX;
    end else begin
      kind = WIN_NONE;
      idx  = '0;
    end
    pend = (kind != WIN_NONE);
  end
endmodule

// File: rtl/intc_shared_top.sv
`timescale 1ns/1ps
module intc_shared_top
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_PAIRS = 8,
  parameter int unsigned NUM_EXT   = 5,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 2),
  localparam int unsigned NUM_INT  = NUM_SLOTS - NUM_EXT,
  localparam int unsigned NUM_BYTES = NUM_SLOTS / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic [1:0]         ext_alt,
  input  logic [NUM_INT-1:0] int_src,
  input  logic [NUM_PAIRS-1:0] alt_src,
  input  logic               brk_req,
  input  logic               irq_ack,
  input  logic               iflag_clr,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_pend,
  output logic [IDX_W-1:0]   irq_vec,
  output logic               iflag
);
  localparam logic [7:0] EN_BASE = ADDR_REQ_BASE + 8'(NUM_BYTES);

  // reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync = rst_pipe_q[1];

  // configuration and control state
  logic [NUM_SLOTS-1:0] en_q, en_d;
  logic [NUM_PAIRS-1:0] src_q, src_d;
  logic [7:0]           edge_q, edge_d;
  logic                 cfg_we;
  logic                 iflag_q, iflag_d;
  logic                 rst_pend_q, rst_pend_d;
  logic                 brk_pend_q, brk_pend_d;

  logic [NUM_SLOTS-1:0] sw_clr, ack_clr;
  logic [NUM_SLOTS-1:0] slot_req, slot_rise, lvl_a;
  logic [NUM_EXT-1:0]   ext_lvl;
  logic [NUM_SLOTS-1:0] win_slot;
  win_kind_e            win_kind;
  logic                 ack_fire;

  intc_edge_front #(
    .NUM_EXT    (NUM_EXT),
    .ALT_LO_IDX (0),
    .ALT_HI_IDX (4)
  ) u_front (
    .clk      (clk),
    .rst_ni   (rst_sync),
    .pin_main (ext_pin),
    .pin_alt  (ext_alt),
    .fall_sel (edge_q[NUM_EXT-1:0]),
    .pin_swap (edge_q[PINSEL_BIT]),
    .ext_lvl  (ext_lvl)
  );

  assign lvl_a = {int_src, ext_lvl};

  intc_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_PAIRS (NUM_PAIRS)
  ) u_bank (
    .clk     (clk),
    .rst_ni  (rst_sync),
    .lvl_a   (lvl_a),
    .lvl_b   (alt_src),
    .src_sel (src_q),
    .sw_clr  (sw_clr),
    .ack_clr (ack_clr),
    .req     (slot_req),
    .rise    (slot_rise)
  );

  intc_prio #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_prio (
    .req        (slot_req),
    .en         (en_q),
    .mask       (iflag_q),
    .reset_pend (rst_pend_q),
    .brk_pend   (brk_pend_q),
    .pend       (irq_pend),
    .idx        (irq_vec),
    .kind       (win_kind),
    .win_slot   (win_slot)
  );

  assign ack_fire = irq_ack & irq_pend;
  assign ack_clr  = (ack_fire && (win_kind == WIN_SLOT)) ? win_slot : '0;

  // register write decode
  always_comb begin
    en_d   = en_q;
    src_d  = src_q;
    edge_d = edge_q;
    sw_clr = '0;
    cfg_we = 1'b0;
    if (reg_we) begin
      if (reg_addr == ADDR_SRCSEL) begin
        src_d  = reg_wdata[NUM_PAIRS-1:0];
        cfg_we = 1'b1;
      end
      if (reg_addr == ADDR_EDGESEL) begin
        edge_d = reg_wdata;
        cfg_we = 1'b1;
      end
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (reg_addr == (ADDR_REQ_BASE + 8'(k))) sw_clr[8*k +: 8] = ~reg_wdata;
        if (reg_addr == (EN_BASE + 8'(k))) begin
          en_d[8*k +: 8] = reg_wdata;
          cfg_we         = 1'b1;
        end
      end
    end
  end

  // control next state
  always_comb begin
    if (ack_fire)       iflag_d = 1'b1;
    else if (iflag_clr) iflag_d = 1'b0;
    else                iflag_d = iflag_q;
    rst_pend_d = rst_pend_q & ~(ack_fire && (win_kind == WIN_RESET));
    brk_pend_d = brk_req | (brk_pend_q & ~(ack_fire && (win_kind == WIN_BRK)));
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      en_q   <= '0;
      src_q  <= '0;
      edge_q <= '0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      src_q  <= src_d;
      edge_q <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      iflag_q    <= 1'b1;
      rst_pend_q <= 1'b1;
      brk_pend_q <= 1'b0;
    end else begin
      iflag_q    <= iflag_d;
      rst_pend_q <= rst_pend_d;
      brk_pend_q <= brk_pend_d;
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_SRCSEL)  reg_rdata = 8'(src_q);
    if (reg_addr == ADDR_EDGESEL) reg_rdata = edge_q;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (reg_addr == (ADDR_REQ_BASE + 8'(k))) reg_rdata = slot_req[8*k +: 8];
      if (reg_addr == (EN_BASE + 8'(k)))       reg_rdata = en_q[8*k +: 8];
    end
  end

  assign iflag = iflag_q;
endmodule

// File: rtl/intc_shared_chk.sv
`timescale 1ns/1ps
module intc_shared_chk #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 irq_ack,
  input logic                 irq_pend,
  input logic [IDX_W-1:0]     irq_vec,
  input logic                 iflag,
  input logic                 iflag_clr,
  input logic [NUM_SLOTS-1:0] slot_req,
  input logic [NUM_SLOTS-1:0] en_q,
  input logic [NUM_SLOTS-1:0] slot_rise,
  input logic                 rst_pend_q
);
  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(NUM_SLOTS + 1);

  logic             vec_is_slot;
  logic [IDX_W-1:0] vec_m1;
  assign vec_is_slot = (irq_vec != '0) && (irq_vec != BRK_IDX);
  assign vec_m1      = irq_vec - IDX_W'(1);

  AST_MASK_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_ni)
    (iflag && irq_pend) |-> (irq_vec == '0 || irq_vec == BRK_IDX)); // R1

  AST_WINNER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_pend && vec_is_slot) |-> (slot_req[vec_m1] && en_q[vec_m1])); // R1

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((slot_req & ~$past(slot_req) & ~$past(slot_rise)) == '0)); // R2

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_pend_q |-> (irq_pend && irq_vec == '0)); // R4

  AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack && irq_pend) |=> iflag); // R5

  AST_ACK_RETIRES_SLOT: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack && irq_pend && vec_is_slot && !slot_rise[vec_m1]) |=> !slot_req[$past(vec_m1)]); // R5

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (($past(slot_rise) & ~slot_req) == '0)); // R10

  AST_MASK_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(iflag) |-> ($past(iflag_clr) && !$past(irq_ack && irq_pend))); // R11
endmodule

bind intc_shared_top intc_shared_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync),
  .irq_ack    (irq_ack),
  .irq_pend   (irq_pend),
  .irq_vec    (irq_vec),
  .iflag      (iflag),
  .iflag_clr  (iflag_clr),
  .slot_req   (slot_req),
  .en_q       (en_q),
  .slot_rise  (slot_rise),
  .rst_pend_q (rst_pend_q)
);

// File: tb/intc_shared_top_test.sv
`timescale 1ns/1ps
module intc_shared_top_test;
  localparam int NS = 16;
  localparam int NP = 8;
  localparam int NE = 5;
  localparam int NI = NS - NE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] ext_pin = '0;
  logic [1:0]    ext_alt = '0;
  logic [NI-1:0] int_src = '0;
  logic [NP-1:0] alt_src = '0;
  logic brk_req = 1'b0, irq_ack = 1'b0, iflag_clr = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_pend, iflag;
  logic [4:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  intc_shared_top uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_alt(ext_alt),
    .int_src(int_src), .alt_src(alt_src), .brk_req(brk_req),
    .irq_ack(irq_ack), .iflag_clr(iflag_clr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pend(irq_pend), .irq_vec(irq_vec), .iflag(iflag)
  );

  // behavioural reference state
  logic [NE+1:0] m_s1, m_s2;
  logic [NS-1:0] m_prev, m_req, m_en;
  logic [7:0]    m_src, m_edge;
  logic          m_i, m_rp, m_bp;
  int            m_cnt;

  function automatic logic [NS-1:0] m_levels();
    logic [NS-1:0] l;
    logic [NE-1:0] ex;
    for (int e = 0; e < NE; e++) begin
      logic p;
      p = m_s2[e];
      if (m_edge[6] && e == 0) p = m_s2[NE];
      if (m_edge[6] && e == 4) p = m_s2[NE+1];
      ex[e] = p ^ m_edge[e];
    end
    for (int s = 0; s < NS; s++) begin
      if (s < NE) l[s] = ex[s];
      else        l[s] = int_src[s-NE];
      if (s < NP && m_src[s]) l[s] = alt_src[s];
    end
    return l;
  endfunction

  function automatic int m_winner();
    if (m_rp) return 0;
    if (!m_i) begin
      for (int s = 0; s < NS; s++) if (m_req[s] && m_en[s]) return s + 1;
    end
    if (m_bp) return NS + 1;
    return -1;
  endfunction

  function automatic logic [7:0] m_rdata(input logic [7:0] a);
    case (a)
      8'h39: return m_src;
      8'h3A: return m_edge;
      8'h3C: return m_req[7:0];
      8'h3D: return m_req[15:8];
      8'h3E: return m_en[7:0];
      8'h3F: return m_en[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_req = '0; m_en = '0;
      m_src = '0; m_edge = '0; m_i = 1'b1; m_rp = 1'b1; m_bp = 1'b0;
      m_cnt = 0;
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      logic [NS-1:0] lvl, rise, clr, sw;
      int w;
      bit fire;
      lvl  = m_levels();
      rise = lvl & ~m_prev;
      w    = m_winner();
      fire = irq_ack && (w >= 0);
      clr  = '0;
      if (fire && w >= 1 && w <= NS) clr[w-1] = 1'b1;
      sw = '0;
      if (reg_we && reg_addr == 8'h3C) sw[7:0]  = ~reg_wdata;
      if (reg_we && reg_addr == 8'h3D) sw[15:8] = ~reg_wdata;
      m_req = (m_req & ~clr & ~sw) | rise;
      if (reg_we) begin
        case (reg_addr)
          8'h39: m_src  = reg_wdata;
          8'h3A: m_edge = reg_wdata;
          8'h3E: m_en[7:0]  = reg_wdata;
          8'h3F: m_en[15:8] = reg_wdata;
          default: ;
        endcase
      end
      if (fire)           m_i = 1'b1;
      else if (iflag_clr) m_i = 1'b0;
      if (fire && w == 0) m_rp = 1'b0;
      if (brk_req)                 m_bp = 1'b1;
      else if (fire && w == NS+1)  m_bp = 1'b0;
      m_prev = lvl;
      m_s2   = m_s1;
      m_s1   = {ext_alt, ext_pin};
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      int w;
      w = m_winner();
      chk("R1 irq_pend vs model", {7'd0, irq_pend}, {7'd0, w >= 0});
      chk("R4 irq_vec vs model", {3'd0, irq_vec}, (w >= 0) ? 8'(w) : 8'd0);
      chk("R11 iflag vs model", {7'd0, iflag}, {7'd0, m_i});
      chk("R13 reg_rdata vs model", reg_rdata, m_rdata(reg_addr));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    cmp_on = 1'b1;
    chk("R3 reset pending", {7'd0, irq_pend}, 8'd1);
    chk("R3 reset index", {3'd0, irq_vec}, 8'd0);
    chk("R11 iflag reset value", {7'd0, iflag}, 8'd1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R5 pend drops after reset ack", {7'd0, irq_pend}, 8'd0);

    wr(8'h3E, 8'hFF);
    wr(8'h3F, 8'hFF);
    iflag_clr = 1'b1; step(); iflag_clr = 1'b0;
    chk("R11 iflag cleared", {7'd0, iflag}, 8'd0);

    int_src[0] = 1'b1; step();
    chk("R1 slot5 pending", {7'd0, irq_pend}, 8'd1);
    chk("R12 internal edge one cycle, index 6", {3'd0, irq_vec}, 8'd6);
    int_src[2] = 1'b1; step();
    chk("R4 slot5 beats slot7", {3'd0, irq_vec}, 8'd6);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R5 iflag set by ack", {7'd0, iflag}, 8'd1);
    chk("R5 masked after ack", {7'd0, irq_pend}, 8'd0);
    iflag_clr = 1'b1; step(); iflag_clr = 1'b0;
    chk("R4 slot7 next winner", {3'd0, irq_vec}, 8'd8);

    wr(8'h3C, 8'hFF);
    chk("R2 write of ones sets nothing", reg_rdata, 8'h80);
    wr(8'h3C, 8'h7F);
    chk("R2 write zero clears", reg_rdata, 8'h00);

    int_src[1] = 1'b1;
    wr(8'h3C, 8'h00);
    chk("R10 edge beats software clear", reg_rdata, 8'h40);
    int_src = '0;
    wr(8'h3C, 8'h00);

    alt_src[2] = 1'b1; step();
    wr(8'h39, 8'h04);
    reg_addr = 8'h3C; step();
    chk("R9 select change sets request", reg_rdata, 8'h04);
    wr(8'h3C, 8'h00);
    alt_src[2] = 1'b0; step();
    alt_src[2] = 1'b1; step();
    chk("R6 alternate source feeds slot2", reg_rdata, 8'h04);
    wr(8'h3C, 8'h00);

    ext_pin[1] = 1'b1;
    step(); step();
    chk("R12 pin not yet seen", reg_rdata, 8'h00);
    step();
    chk("R12 pin seen third edge", reg_rdata, 8'h02);
    wr(8'h3C, 8'h00);
    wr(8'h3A, 8'h02);
    reg_addr = 8'h3C; step();
    ext_pin[1] = 1'b0;
    step(); step(); step();
    chk("R8 falling polarity detects", reg_rdata, 8'h02);
    wr(8'h3C, 8'h00);

    ext_alt[0] = 1'b1;
    repeat (4) step();
    chk("R7 alternate pin ignored when not swapped", reg_rdata, 8'h00);
    wr(8'h3A, 8'h42);
    reg_addr = 8'h3C; step();
    chk("R7 swapped pin sets slot0", reg_rdata, 8'h01);

    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    brk_req = 1'b1; step(); brk_req = 1'b0;
    chk("R3 break pending while masked", {7'd0, irq_pend}, 8'd1);
    chk("R3 break index", {3'd0, irq_vec}, 8'd17);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;

    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) int_src[$urandom_range(0, NI-1)] ^= 1'b1;
      if (r > 85) alt_src[$urandom_range(0, NP-1)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) ext_pin[$urandom_range(0, NE-1)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) ext_alt[$urandom_range(0, 1)] ^= 1'b1;
      brk_req   = ($urandom_range(0, 39) == 0);
      irq_ack   = ($urandom_range(0, 9) < 3);
      iflag_clr = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 9) == 0) begin
        int a;
        a = $urandom_range(0, 5);
        reg_we    = 1'b1;
        reg_addr  = (a == 0) ? 8'h39 : (a == 1) ? 8'h3A : 8'(8'h3A + a);
        reg_wdata = 8'($urandom_range(0, 255));
      end else begin
        reg_we   = 1'b0;
        reg_addr = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'(8'h39 + $urandom_range(0, 6));
      end
      step();
    end
    reg_we = 1'b0; irq_ack = 1'b0; iflag_clr = 1'b0; brk_req = 1'b0;
    step();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule